// File: doc/BRIEF.md
# CPU Boot Sequencer with Reset and Clock Release

This block sits beside an 8-bit main processor and decides when that processor may run. It runs from a 16 MHz reference clock. It stays idle until an enable line called RUN goes high, then steps through six numbered stages, 0 to 5. It captures the state of a user button for a later boot-menu decision, gives the system bus time to settle, and fixes the processor clock rate. It then waits for an external loader to report that a boot image sits in memory.

The processor clock comes from the reference by division. It is 8 MHz (divide by 2) when the stored speed bit is 1 and 4 MHz (divide by 4) when it is 0. In the final stage the block starts that clock while the processor is still held in reset. It lets a fixed number of processor clock edges pass, gives a receive buffer a single-cycle flush pulse, and only then lets go of reset. When RUN falls at any point, everything returns to stage 0 with the processor held.

Top module: `boot_seq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `stage_o` is 0, `cpu_rst_n_o` is 0, `cpu_clk_o` is 0, `flush_o` is 0 and `menu_req_o` is 0.
- R2: While `run_i` is low, `stage_o` stays at 0 and the processor stays in reset with its clock stopped.
- R3: The first clock edge that sees `run_i` high in stage 0 moves to stage 1 and sets `menu_req_o` to the inverse of `user_btn_n_i` at that edge (button low, meaning pressed, gives 1). Later button changes leave `menu_req_o` unchanged.
- R4: `stage_o` only ever moves up by exactly one, or back to 0. A complete boot passes through 0, 1, 2, 3, 4 and 5 in that order.
- R5: In stage 4 the block stays put, with the processor in reset, for as long as `image_ready_i` is low. It enters stage 5 on the edge after `image_ready_i` is seen high.
- R6: `cpu_rst_n_o` (active low) is 0 in every stage below 5, and also in stage 5 until the flush pulse has been given.
- R7: `cpu_clk_o` is low outside stage 5. In stage 5 it runs with a period of 2 reference cycles when the speed bit was 1 and 4 reference cycles when it was 0.
- R8: The speed bit is taken from `speed_fast_i` only in stage 3, while reset is held. Changes afterwards do not alter the processor clock period.
- R9: At least 8 rising edges of `cpu_clk_o` occur before the flush pulse. Reset is released on the reference cycle right after the flush pulse.
- R10: `flush_o` is high for exactly one reference cycle per boot, and only while the processor is still held in reset.
- R11: When `run_i` is seen low, the next reference cycle shows stage 0, `cpu_rst_n_o` 0, `cpu_clk_o` 0 and `menu_req_o` 0, whatever the stage was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Boot enable; low returns to stage 0 |
| user_btn_n_i | input | 1 | User button, low when pressed |
| speed_fast_i | input | 1 | Stored speed bit: 1 selects 8 MHz, 0 selects 4 MHz |
| image_ready_i | input | 1 | Loader handshake: boot image is in memory |
| cpu_clk_o | output | 1 | Divided processor clock |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| menu_req_o | output | 1 | Boot menu requested (button held when RUN arrived) |
| flush_o | output | 1 | One-cycle serial receive buffer flush strobe |
| stage_o | output | 3 | Current boot stage, 0 to 5 |

## Verification
The full boot is run for all four pairings of button level and speed bit. These runs separate a menu flag taken from the button from one that is stuck, and a divide-by-2 clock from a divide-by-4 clock. During each run the button and the speed input are flipped after they have been sampled. A design that samples them late would then show the wrong flag or the wrong clock period. Directed cases hold RUN low, stall the loader handshake in stage 4, and drop RUN in the middle of a boot and again after release, which shows whether the return to stage 0 clears every output.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_RUN = 3'd0,
    ST_SAMPLE   = 3'd1,
    ST_BUS_INIT = 3'd2,
    ST_CONFIG   = 3'd3,
    ST_LOAD     = 3'd4,
    ST_RELEASE  = 3'd5
  } stage_t;

  typedef enum logic [1:0] {
    PH_CLOCK = 2'd0,
    PH_FLUSH = 2'd1,
    PH_RUN   = 2'd2
  } rel_phase_t;

endpackage

// File: rtl/cpu_clk_div.sv
module cpu_clk_div #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_next_i,
  input  logic fast_i,
  output logic cpu_clk_o,
  output logic rise_o
);
  localparam int CNT_W    = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int FAST_BIT = (FAST_DIV > 2) ? $clog2(FAST_DIV) - 1 : 0;
  localparam int SLOW_BIT = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             clk_q;
  logic             clk_prev_q;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en_next_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_inc;
      clk_q <= fast_i ? cnt_inc[FAST_BIT] : cnt_inc[SLOW_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_prev_q <= 1'b0;
    else     clk_prev_q <= clk_q;
  end

  assign cpu_clk_o = clk_q;
  assign rise_o    = clk_q & ~clk_prev_q;
endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int HOLD_EDGES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic rise_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(HOLD_EDGES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_EDGES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)                 cnt_q <= '0;
    else if (rise_i && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/boot_stage_fsm.sv
module boot_stage_fsm
  import boot_pkg::*;
#(
  parameter int DWELL_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       user_btn_n_i,
  input  logic       speed_fast_i,
  input  logic       image_ready_i,
  input  logic       hold_done_i,
  output stage_t     stage_o,
  output logic       menu_o,
  output logic       speed_o,
  output logic       clk_en_next_o,
  output logic       timer_en_o,
  output logic       flush_o,
  output logic       cpu_rst_n_o
);
  localparam int DW_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL_CYC - 1);

  stage_t     stage_q, stage_d;
  rel_phase_t phase_q, phase_d;
  logic [DW_W-1:0] dwell_q, dwell_d;
  logic menu_q, menu_d;
  logic speed_q, speed_d;
  logic flush_q, flush_d;
  logic rstn_q, rstn_d;

  always_comb begin
    stage_d = stage_q;
    phase_d = phase_q;
    dwell_d = dwell_q;
    menu_d  = menu_q;
    speed_d = speed_q;
    flush_d = 1'b0;
    rstn_d  = rstn_q;
    if (!run_i) begin
      stage_d = ST_WAIT_RUN;
      phase_d = PH_CLOCK;
      dwell_d = '0;
      menu_d  = 1'b0;
      rstn_d  = 1'b0;
    end else begin
      unique case (stage_q)
        ST_WAIT_RUN: begin
          stage_d = ST_SAMPLE;
          menu_d  = ~user_btn_n_i;
          rstn_d  = 1'b0;
        end
        ST_SAMPLE: begin
          stage_d = ST_BUS_INIT;
          dwell_d = '0;
        end
        ST_BUS_INIT: begin
          if (dwell_q == DW_LAST) stage_d = ST_CONFIG;
          else                    dwell_d = dwell_q + 1'b1;
        end
        ST_CONFIG: begin
          speed_d = speed_fast_i;
          stage_d = ST_LOAD;
        end
        ST_LOAD: begin
          if (image_ready_i) begin
            stage_d = ST_RELEASE;
            phase_d = PH_CLOCK;
          end
        end
        ST_RELEASE: begin
          unique case (phase_q)
            PH_CLOCK: if (hold_done_i) begin
              phase_d = PH_FLUSH;
              flush_d = 1'b1;
            end
            PH_FLUSH: begin
              phase_d = PH_RUN;
              rstn_d  = 1'b1;
            end
            default: phase_d = PH_RUN;
          endcase
        end
        default: stage_d = ST_WAIT_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_WAIT_RUN;
      phase_q <= PH_CLOCK;
      dwell_q <= '0;
      menu_q  <= 1'b0;
      speed_q <= 1'b0;
      flush_q <= 1'b0;
      rstn_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      phase_q <= phase_d;
      dwell_q <= dwell_d;
      menu_q  <= menu_d;
      speed_q <= speed_d;
      flush_q <= flush_d;
      rstn_q  <= rstn_d;
    end
  end

  assign stage_o       = stage_q;
  assign menu_o        = menu_q;
  assign speed_o       = speed_q;
  assign clk_en_next_o = (stage_d == ST_RELEASE);
  assign timer_en_o    = (stage_q == ST_RELEASE) && (phase_q == PH_CLOCK);
  assign flush_o       = flush_q;
  assign cpu_rst_n_o   = rstn_q;
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_pkg::*;
#(
  parameter int DWELL_CYC  = 4,
  parameter int HOLD_EDGES = 8,
  parameter int FAST_DIV   = 2,
  parameter int SLOW_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       user_btn_n_i,
  input  logic       speed_fast_i,
  input  logic       image_ready_i,
  output logic       cpu_clk_o,
  output logic       cpu_rst_n_o,
  output logic       menu_req_o,
  output logic       flush_o,
  output logic [2:0] stage_o
);
  stage_t stage;
  logic   speed_sel;
  logic   clk_en_next;
  logic   timer_en;
  logic   hold_done;
  logic   cpu_rise;

  boot_stage_fsm #(.DWELL_CYC(DWELL_CYC)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .run_i         (run_i),
    .user_btn_n_i  (user_btn_n_i),
    .speed_fast_i  (speed_fast_i),
    .image_ready_i (image_ready_i),
    .hold_done_i   (hold_done),
    .stage_o       (stage),
    .menu_o        (menu_req_o),
    .speed_o       (speed_sel),
    .clk_en_next_o (clk_en_next),
    .timer_en_o    (timer_en),
    .flush_o       (flush_o),
    .cpu_rst_n_o   (cpu_rst_n_o)
  );

  cpu_clk_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .en_next_i (clk_en_next),
    .fast_i    (speed_sel),
    .cpu_clk_o (cpu_clk_o),
    .rise_o    (cpu_rise)
  );

  release_timer #(.HOLD_EDGES(HOLD_EDGES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .en_i   (timer_en),
    .rise_i (cpu_rise),
    .done_o (hold_done)
  );

  assign stage_o = stage;
endmodule

// File: rtl/boot_seq_ctrl_chk.sv
module boot_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       run_i,
  input logic [2:0] stage_o,
  input logic       cpu_rst_n_o,
  input logic       cpu_clk_o,
  input logic       flush_o,
  input logic       menu_req_o,
  input logic       speed_sel
);
  // R6: processor held in reset in every stage below 5
  a_r6_reset_held: assert property (@(posedge clk) disable iff (rst)
    (stage_o != 3'd5) |-> !cpu_rst_n_o);

  // R7: clock stopped outside the release stage
  a_r7_clock_gated: assert property (@(posedge clk) disable iff (rst)
    (stage_o != 3'd5) |-> !cpu_clk_o);

  // R4: stage steps up by one or returns to 0
  a_r4_stage_order: assert property (@(posedge clk) disable iff (rst)
    !$stable(stage_o) |-> (stage_o == 3'd0 || stage_o == $past(stage_o) + 3'd1));

  // R10: flush lasts a single reference cycle and only under reset
  a_r10_flush_single: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);
  a_r10_flush_in_reset: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> !cpu_rst_n_o);

  // R9: reset leaves right after the flush pulse
  a_r9_release_after_flush: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rst_n_o) |-> $past(flush_o));

  // R11: RUN low forces stage 0 with reset asserted
  a_r11_run_drop: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (stage_o == 3'd0 && !cpu_rst_n_o && !menu_req_o));

  // R3: menu flag changes only on entry to stage 1 or on return to 0
  a_r3_menu_latched: assert property (@(posedge clk) disable iff (rst)
    !$stable(menu_req_o) |-> (stage_o == 3'd1 || stage_o == 3'd0));

  // R8: ratio frozen while in the release stage
  a_r8_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd5 && $past(stage_o) == 3'd5) |-> $stable(speed_sel));
endmodule

bind boot_seq_ctrl boot_seq_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .stage_o     (stage_o),
  .cpu_rst_n_o (cpu_rst_n_o),
  .cpu_clk_o   (cpu_clk_o),
  .flush_o     (flush_o),
  .menu_req_o  (menu_req_o),
  .speed_sel   (speed_sel)
);

// File: tb/tb_boot_seq_ctrl.sv
module tb_boot_seq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_i = 1'b0;
  logic user_btn_n_i = 1'b1;
  logic speed_fast_i = 1'b0;
  logic image_ready_i = 1'b0;
  logic cpu_clk_o, cpu_rst_n_o, menu_req_o, flush_o;
  logic [2:0] stage_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_seq_ctrl dut (
    .clk(clk), .rst(rst), .run_i(run_i), .user_btn_n_i(user_btn_n_i),
    .speed_fast_i(speed_fast_i), .image_ready_i(image_ready_i),
    .cpu_clk_o(cpu_clk_o), .cpu_rst_n_o(cpu_rst_n_o), .menu_req_o(menu_req_o),
    .flush_o(flush_o), .stage_o(stage_o)
  );

  // {user_btn_n, speed_fast, expected menu, expected period[2:0]}
  localparam logic [5:0] VEC [4] = '{
    {1'b0, 1'b1, 1'b1, 3'd2},
    {1'b1, 1'b1, 1'b0, 3'd2},
    {1'b0, 1'b0, 1'b1, 3'd4},
    {1'b1, 1'b0, 1'b0, 3'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // full boot: returns observations
  int  r_stage_bad, r_rises, r_flush_cnt, r_flush_bad, r_period, r_menu;
  bit  r_reached5, r_stall_ok;

  task automatic boot(input logic user_n, input logic fast);
    int prev_stage;
    bit prev_clk;
    int rises;
    int stall;
    bit released;
    r_stage_bad = 0; r_flush_cnt = 0; r_flush_bad = 0; r_rises = 0;
    r_reached5 = 0; r_stall_ok = 1; r_period = 0;
    @(negedge clk);
    user_btn_n_i = user_n;
    speed_fast_i = fast;
    image_ready_i = 1'b0;
    run_i = 1'b1;
    prev_stage = 0; prev_clk = 0; rises = 0; stall = 0; released = 0;
    for (int i = 0; i < 300 && !released; i++) begin
      @(negedge clk);
      if (stage_o != prev_stage[2:0] && stage_o != prev_stage[2:0] + 3'd1)
        r_stage_bad++;
      if (stage_o == 3'd2) user_btn_n_i = ~user_n;      // late change, ignored
      if (stage_o == 3'd4) begin
        speed_fast_i = ~fast;                           // late change, ignored
        if (cpu_rst_n_o || cpu_clk_o) r_stall_ok = 0;
        stall++;
        if (stall == 12) image_ready_i = 1'b1;
      end
      if (stage_o == 3'd5) r_reached5 = 1;
      if (cpu_clk_o && !prev_clk && !cpu_rst_n_o) rises++;
      if (flush_o) begin
        r_flush_cnt++;
        if (cpu_rst_n_o || rises < 8) r_flush_bad++;
      end
      if (cpu_rst_n_o) released = 1;
      prev_clk = cpu_clk_o;
      prev_stage = int'(stage_o);
    end
    r_rises = rises;
    r_menu = int'(menu_req_o);
    begin
      int first;
      int second;
      first = -1; second = -1;
      for (int i = 0; i < 40 && second < 0; i++) begin
        @(negedge clk);
        if (flush_o) r_flush_cnt++;
        if (cpu_clk_o && !prev_clk) begin
          if (first < 0) first = i; else second = i;
        end
        prev_clk = cpu_clk_o;
      end
      r_period = second - first;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(stage_o == 3'd0 && !cpu_rst_n_o && !cpu_clk_o && !flush_o && !menu_req_o,
        "R1 reset state", {stage_o, cpu_rst_n_o, cpu_clk_o, flush_o, menu_req_o}, 0);
    rst = 1'b0;
    // R2: idle while RUN low
    begin
      bit moved;
      moved = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (stage_o != 3'd0 || cpu_rst_n_o || cpu_clk_o) moved = 1;
      end
      chk(!moved, "R2 idle without RUN", int'(moved), 0);
    end

    for (int v = 0; v < 4; v++) begin
      boot(VEC[v][5], VEC[v][4]);
      chk(r_menu == int'(VEC[v][3]), "R3 menu flag sampled at RUN", r_menu, int'(VEC[v][3]));
      chk(r_stage_bad == 0 && r_reached5, "R4 stage order", r_stage_bad, 0);
      chk(r_stall_ok, "R5 stage 4 stall holds reset", int'(r_stall_ok), 1);
      chk(cpu_rst_n_o, "R6 reset released after sequence", int'(cpu_rst_n_o), 1);
      chk(r_period == int'(VEC[v][2:0]), "R7 R8 cpu clock period", r_period, int'(VEC[v][2:0]));
      chk(r_rises >= 8 && r_flush_bad == 0, "R9 edges before flush", r_rises, 8);
      chk(r_flush_cnt == 1, "R10 single flush", r_flush_cnt, 1);
      // R11: drop RUN after release
      @(negedge clk); run_i = 1'b0;
      @(negedge clk);
      chk(stage_o == 3'd0 && !cpu_rst_n_o && !cpu_clk_o && !menu_req_o,
          "R11 run drop after release", int'(stage_o), 0);
      repeat (3) @(negedge clk);
    end

    // R11: drop RUN mid-boot (stage 2)
    @(negedge clk); user_btn_n_i = 1'b0; run_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(stage_o == 3'd2 && menu_req_o, "R3 mid-boot stage 2 with menu", int'(stage_o), 2);
    run_i = 1'b0;
    @(negedge clk);
    chk(stage_o == 3'd0 && !menu_req_o && !cpu_rst_n_o, "R11 run drop mid-boot",
        int'(stage_o), 0);

    // R5: long stall in stage 4 without handshake
    run_i = 1'b1; image_ready_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(stage_o == 3'd4 && !cpu_rst_n_o && !cpu_clk_o && !flush_o,
        "R5 waits for image", int'(stage_o), 4);
    run_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule